// File: doc/BRIEF.md
# Flash Burst Access FIFO Engine

This engine sits between a host register port and a flash device. The host reads from flash in bursts. It sets a start word address, then arms a burst with one control write that carries both a word count and a read-mode flag. The engine issues consecutive word reads on a valid/ready request port and collects the responses in a FIFO. The host then empties the FIFO by reading one fixed data offset over and over.

The same FIFO carries data the other way for programming. The host pushes words by writing the data offset. A local controller drains them through a simple pop port. The host paces its pushes with a free-space field that sits in the same control register as the busy flag.

Ownership of the flash is shared between the host and the local controller. The host raises a request bit. The local controller answers with a grant. A status bit, together with a flash-select output, shows when ownership has actually moved to the host.

The register map uses word offsets:
- 0: start address
- 1: control
- 2: FIFO data
- 3: ownership

Top module: `flash_burst_engine`

## Requirements
- R1: After reset the control register reads mode 0, busy 0, error 0, overflow 0, count 0 and free field equal to DEPTH. The ownership register reads 0, a read of the FIFO offset returns 0, and no flash request or ownership request is driven.
- R2: An accepted burst issues flash reads at consecutive word addresses, starting at the value held at offset 0, with one request outstanding at a time. Each request holds valid and address steady until ready is seen.
- R3: Control bit 1 (busy) is set from the start of an accepted burst. It clears on the clock edge that places the last requested word in the FIFO, at which point the free field (bits starting at 16) has dropped by the burst length.
- R4: Each read of offset 2 returns the oldest FIFO word and removes it, so burst data comes back in address order. A read of offset 2 while the FIFO is empty returns 0 and leaves the word count unchanged.
- R5: While no burst is running, each write to offset 2 appends one word and lowers the free field by one. The local pop port presents those words oldest first, with loc_avail high while words remain.
- R6: A push into a full FIFO is discarded and sets control bit 3 (overflow), which stays set until the control register is written with 0.
- R7: Writing 0 to the control register stops any burst, so busy reads 0 and no flash request follows. It also empties the FIFO, so free equals DEPTH, and clears the mode, count, error and overflow fields.
- R8: A burst start (control bit 0 set, nonzero count) while the host does not own the flash is refused. Busy stays 0, no flash request is made, and control bit 2 (error) is set.
- R9: A burst start whose count field (bits starting at 8) exceeds DEPTH is refused the same way, with the error bit set.
- R10: Bit 0 of offset 3 drives own_req. Bit 1 of offset 3 and fl_host_sel rise within two cycles of request and grant both being high. They fall within two cycles of the request being cleared.
- R11: Host writes to offset 2 while busy is set are discarded and do not reach the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops when offset is 2) |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of the strobe |
| fl_rd_valid | output | 1 | Flash read request valid |
| fl_rd_ready | input | 1 | Flash accepts the request |
| fl_rd_addr | output | 16 | Flash word address of the request |
| fl_rsp_valid | input | 1 | Flash read data valid |
| fl_rsp_data | input | 32 | Flash read data |
| own_req | output | 1 | Host ownership request to the local controller |
| own_gnt | input | 1 | Grant from the local controller |
| fl_host_sel | output | 1 | Flash path switched to the host |
| loc_pop | input | 1 | Local controller removes the head word (host read wins a tie) |
| loc_data | output | 32 | Head word for the local controller, 0 when empty |
| loc_avail | output | 1 | FIFO holds at least one word |

## Verification
Several properties are checked on every cycle by the assertions:
- the request handshake keeps valid and address stable until ready;
- a burst only begins while the host owns the flash;
- the FIFO count never passes DEPTH, an empty pop leaves it at zero, and a full FIFO stays full when it refuses a push;
- a zero control write leaves the sequencer idle on the next cycle;
- a dropped request removes ownership.

Other properties depend on data values and can only be shown by the bench's scenarios:
- burst data returns in address order;
- the free and count fields hold the right values at burst end;
- words pushed by the host come out of the local port intact;
- the overflow and error bits are sticky until cleared, and refusals leave the flash untouched.

// File: rtl/fbe_pkg.sv
package fbe_pkg;
  localparam logic [1:0] OFS_ADDR = 2'd0;
  localparam logic [1:0] OFS_CTRL = 2'd1;
  localparam logic [1:0] OFS_FIFO = 2'd2;
  localparam logic [1:0] OFS_MUX  = 2'd3;

  localparam int CTRL_MODE_BIT = 0;
  localparam int CTRL_BUSY_BIT = 1;
  localparam int CTRL_ERR_BIT  = 2;
  localparam int CTRL_OVF_BIT  = 3;
  localparam int CTRL_CNT_LSB  = 8;
  localparam int CTRL_FREE_LSB = 16;

  localparam int MUX_REQ_BIT = 0;
  localparam int MUX_OWN_BIT = 1;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/fbe_fifo.sv
module fbe_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign count = cnt_q;
  assign head  = mem[rp_q];

  always_comb begin
    do_push = push && !full && !flush;
    do_pop  = pop && !empty && !flush;
    wp_n    = wp_q;
    rp_n    = rp_q;
    cnt_n   = cnt_q;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wp_n = bump(wp_q);
      if (do_pop)  rp_n = bump(rp_q);
      cnt_n = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> (count == '0));
  assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full);
endmodule

// File: rtl/fbe_burst_seq.sv
module fbe_burst_seq
  import fbe_pkg::*;
#(
  parameter int DW    = 32,
  parameter int FAW   = 16,
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctrl_wr,
  input  logic           ctrl_zero,
  input  logic           wr_mode,
  input  logic [CW-1:0]  wr_count,
  input  logic [FAW-1:0] base_addr,
  input  logic           host_owns,
  input  logic           fl_rd_ready,
  input  logic           fl_rsp_valid,
  input  logic [DW-1:0]  fl_rsp_data,
  output logic           fl_rd_valid,
  output logic [FAW-1:0] fl_rd_addr,
  output logic           busy,
  output logic           reject,
  output logic           push,
  output logic [DW-1:0]  push_data
);
  seq_state_t     st_q, st_n;
  logic [FAW-1:0] addr_q, addr_n;
  logic [CW-1:0]  left_q, left_n;
  logic           start_req, start_ok, abort;

  always_comb begin
    start_req = ctrl_wr && wr_mode && (wr_count != '0) && (st_q == SQ_IDLE);
    start_ok  = start_req && host_owns && (wr_count <= CW'(DEPTH));
    reject    = start_req && !start_ok;
    abort     = (ctrl_wr && ctrl_zero) || !host_owns;
    st_n      = st_q;
    addr_n    = addr_q;
    left_n    = left_q;
    push      = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (start_ok) begin
        st_n   = SQ_REQ;
        addr_n = base_addr;
        left_n = wr_count;
      end
      SQ_REQ: if (fl_rd_ready) st_n = SQ_WAIT;
      SQ_WAIT: if (fl_rsp_valid && !abort) begin
        push   = 1'b1;
        addr_n = addr_q + 1'b1;
        left_n = left_q - 1'b1;
        st_n   = (left_q == CW'(1)) ? SQ_IDLE : SQ_REQ;
      end
      default: st_n = SQ_IDLE;
    endcase
    if (abort && st_q != SQ_IDLE) st_n = SQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      addr_q <= '0;
      left_q <= '0;
    end else begin
      st_q   <= st_n;
      addr_q <= addr_n;
      left_q <= left_n;
    end
  end

  assign fl_rd_valid = (st_q == SQ_REQ);
  assign fl_rd_addr  = addr_q;
  assign busy        = (st_q != SQ_IDLE);
  assign push_data   = fl_rsp_data;

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd_valid && !fl_rd_ready && !abort) |=> fl_rd_valid);
  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd_valid && !fl_rd_ready && !abort) |=> $stable(fl_rd_addr));
  assert_start_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(host_owns));
endmodule

// File: rtl/fbe_own_mux.sv
module fbe_own_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic host_req,
  input  logic gnt_in,
  output logic host_owns
);
  logic own_q, own_n;

  always_comb own_n = host_req && gnt_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= 1'b0;
    else        own_q <= own_n;
  end

  assign host_owns = own_q;

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_req) |=> !host_owns);
endmodule

// File: rtl/flash_burst_engine.sv
module flash_burst_engine
  import fbe_pkg::*;
#(
  parameter int DW    = 32,
  parameter int FAW   = 16,
  parameter int DEPTH = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [1:0]     reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           fl_rd_valid,
  input  logic           fl_rd_ready,
  output logic [FAW-1:0] fl_rd_addr,
  input  logic           fl_rsp_valid,
  input  logic [DW-1:0]  fl_rsp_data,
  output logic           own_req,
  input  logic           own_gnt,
  output logic           fl_host_sel,
  input  logic           loc_pop,
  output logic [DW-1:0]  loc_data,
  output logic           loc_avail
);
  localparam int CW = $clog2(DEPTH + 1);

  logic rs1_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q  <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      rs1_q  <= 1'b1;
      srst_n <= rs1_q;
    end
  end

  logic [FAW-1:0] addr_q, addr_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic           mode_q, mode_n, err_q, err_n, ovf_q, ovf_n, req_q, req_n;
  logic           ctrl_wr, ctrl_zero, host_push, host_pop, flush;
  logic           busy, reject, seq_push, host_owns;
  logic [DW-1:0]  seq_data, fifo_head, fifo_wdata;
  logic           fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [CW-1:0]  fifo_count, free_words;

  assign ctrl_wr    = reg_wr && (reg_addr == OFS_CTRL);
  assign ctrl_zero  = (reg_wdata == '0);
  assign host_push  = reg_wr && (reg_addr == OFS_FIFO) && !busy;
  assign host_pop   = reg_rd && (reg_addr == OFS_FIFO);
  assign fifo_push  = seq_push || host_push;
  assign fifo_wdata = seq_push ? seq_data : reg_wdata;
  assign fifo_pop   = host_pop || loc_pop;
  assign free_words = CW'(DEPTH) - fifo_count;

  fbe_burst_seq #(.DW(DW), .FAW(FAW), .DEPTH(DEPTH)) u_seq (
    .clk, .rst_n(srst_n), .ctrl_wr, .ctrl_zero,
    .wr_mode(reg_wdata[CTRL_MODE_BIT]),
    .wr_count(reg_wdata[CTRL_CNT_LSB +: CW]),
    .base_addr(addr_q), .host_owns, .fl_rd_ready, .fl_rsp_valid, .fl_rsp_data,
    .fl_rd_valid, .fl_rd_addr, .busy, .reject, .push(seq_push), .push_data(seq_data)
  );

  fbe_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk, .rst_n(srst_n), .flush, .push(fifo_push), .push_data(fifo_wdata),
    .pop(fifo_pop), .head(fifo_head), .count(fifo_count),
    .empty(fifo_empty), .full(fifo_full)
  );

  fbe_own_mux u_mux (
    .clk, .rst_n(srst_n), .host_req(req_q), .gnt_in(own_gnt), .host_owns
  );

  always_comb begin
    addr_n = addr_q;
    cnt_n  = cnt_q;
    mode_n = mode_q;
    req_n  = req_q;
    err_n  = err_q || reject;
    ovf_n  = ovf_q || (fifo_push && fifo_full);
    flush  = 1'b0;
    if (reg_wr) begin
      unique case (reg_addr)
        OFS_ADDR: addr_n = reg_wdata[FAW-1:0];
        OFS_CTRL: begin
          if (ctrl_zero) begin
            mode_n = 1'b0;
            cnt_n  = '0;
            err_n  = 1'b0;
            ovf_n  = 1'b0;
            flush  = 1'b1;
          end else begin
            mode_n = reg_wdata[CTRL_MODE_BIT];
            cnt_n  = reg_wdata[CTRL_CNT_LSB +: CW];
          end
        end
        OFS_MUX: req_n = reg_wdata[MUX_REQ_BIT];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
      err_q  <= 1'b0;
      ovf_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      addr_q <= addr_n;
      cnt_q  <= cnt_n;
      mode_q <= mode_n;
      err_q  <= err_n;
      ovf_q  <= ovf_n;
      req_q  <= req_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_ADDR: reg_rdata[FAW-1:0] = addr_q;
      OFS_CTRL: begin
        reg_rdata[CTRL_MODE_BIT]          = mode_q;
        reg_rdata[CTRL_BUSY_BIT]          = busy;
        reg_rdata[CTRL_ERR_BIT]           = err_q;
        reg_rdata[CTRL_OVF_BIT]           = ovf_q;
        reg_rdata[CTRL_CNT_LSB +: CW]     = cnt_q;
        reg_rdata[CTRL_FREE_LSB +: CW]    = free_words;
      end
      OFS_FIFO: reg_rdata = fifo_empty ? '0 : fifo_head;
      OFS_MUX: begin
        reg_rdata[MUX_REQ_BIT] = req_q;
        reg_rdata[MUX_OWN_BIT] = host_owns;
      end
      default: ;
    endcase
  end

  assign own_req     = req_q;
  assign fl_host_sel = host_owns;
  assign loc_data    = fifo_empty ? '0 : fifo_head;
  assign loc_avail   = !fifo_empty;

  assert_ctrl_zero_idle_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (ctrl_wr && ctrl_zero) |=> !busy);
endmodule

// File: tb/tb_flash_burst_engine.sv
module tb_flash_burst_engine;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fl_rd_valid, fl_rd_ready = 1'b0;
  logic [15:0] fl_rd_addr;
  logic        fl_rsp_valid = 1'b0;
  logic [31:0] fl_rsp_data = '0;
  logic        own_req, own_gnt = 1'b0, fl_host_sel;
  logic        loc_pop = 1'b0;
  logic [31:0] loc_data;
  logic        loc_avail;

  int checks = 0, fails = 0;
  bit done = 0;
  bit hold = 0;
  bit pend = 0, hs = 0;
  logic [15:0] paddr, hs_addr;
  int req_seen = 0;

  flash_burst_engine #(.DEPTH(DEPTH)) dut (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] fdata(input logic [15:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  function automatic logic [31:0] ctrl_exp(input bit mode, input bit bsy, input bit er,
                                           input bit ov, input int cnt, input int fre);
    return (32'(fre) << 16) | (32'(cnt) << 8) | {28'd0, ov, er, bsy, mode};
  endfunction

  // flash and local controller model
  always @(negedge clk) begin
    if (hs) begin pend = 1; paddr = hs_addr; end
    fl_rsp_valid = 1'b0;
    if (pend && !hold && ($urandom % 3 != 0)) begin
      fl_rsp_valid = 1'b1;
      fl_rsp_data  = fdata(paddr);
      pend = 0;
    end
    fl_rd_ready = !pend && !hold && ($urandom % 4 != 0);
    hs = fl_rd_valid && fl_rd_ready;
    hs_addr = fl_rd_addr;
    if (fl_rd_valid) req_seen++;
    own_gnt = own_req;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic wait_own(input bit want);
    logic [31:0] v;
    for (int i = 0; i < 10; i++) begin
      rd(2'd3, v);
      if (v[1] == want) break;
    end
    chk("R10 own status", {31'd0, v[1]}, {31'd0, want});
    chk("R10 fl_host_sel", {31'd0, fl_host_sel}, {31'd0, want});
  endtask

  task automatic run_burst(input logic [15:0] a, input int n);
    logic [31:0] v;
    wr(2'd0, {16'd0, a});
    wr(2'd1, (32'(n) << 8) | 32'd1);
    rd(2'd1, v);
    chk("R3 busy set", {31'd0, v[1]}, 32'd1);
    for (int i = 0; i < 1000 && v[1]; i++) rd(2'd1, v);
    chk("R3 done ctrl", v, ctrl_exp(1, 0, 0, 0, n, DEPTH - n));
    for (int i = 0; i < n; i++) begin
      rd(2'd2, v);
      chk("R2 R4 burst word", v, fdata(a + 16'(i)));
    end
    rd(2'd2, v);
    chk("R4 empty pop", v, 32'd0);
    rd(2'd1, v);
    chk("R4 free after empty pop", v >> 16, 32'(DEPTH));
    wr(2'd1, 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] pushed [10];
    int base_req;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd1, v); chk("R1 ctrl", v, ctrl_exp(0, 0, 0, 0, 0, DEPTH));
    rd(2'd3, v); chk("R1 mux", v, 32'd0);
    rd(2'd2, v); chk("R1 fifo", v, 32'd0);
    chk("R1 no request", {30'd0, fl_rd_valid, own_req}, 32'd0);

    // R8 refused without ownership
    base_req = req_seen;
    wr(2'd0, 32'h10);
    wr(2'd1, (32'd4 << 8) | 32'd1);
    repeat (5) @(negedge clk);
    rd(2'd1, v); chk("R8 error no busy", v, ctrl_exp(1, 0, 1, 0, 4, DEPTH));
    chk("R8 no flash request", 32'(req_seen - base_req), 32'd0);
    wr(2'd1, 32'd0);
    rd(2'd1, v); chk("R7 error cleared", v, ctrl_exp(0, 0, 0, 0, 0, DEPTH));

    // R10 take ownership
    wr(2'd3, 32'd1);
    wait_own(1);

    // R9 oversize count
    base_req = req_seen;
    wr(2'd1, (32'(DEPTH + 1) << 8) | 32'd1);
    repeat (3) @(negedge clk);
    rd(2'd1, v); chk("R9 oversize refused", v[3:0], 32'b0101);
    chk("R9 no flash request", 32'(req_seen - base_req), 32'd0);
    wr(2'd1, 32'd0);

    // R2 R3 R4 bursts: two directed sizes then random
    run_burst(16'hFFF0, 1);
    run_burst(16'h0100, DEPTH);
    for (int it = 0; it < 10; it++)
      run_burst(16'($urandom % 4096), 1 + int'($urandom % DEPTH));

    // R11 push during busy dropped, R7 abort
    hold = 1;
    wr(2'd0, 32'h40);
    wr(2'd1, (32'd8 << 8) | 32'd1);
    wr(2'd2, 32'hDEADBEEF);
    rd(2'd1, v); chk("R11 busy while held", v[1:0], 32'b11);
    hold = 0;
    for (int i = 0; i < 1000 && v[1]; i++) rd(2'd1, v);
    chk("R11 only burst words", v >> 16, 32'(DEPTH - 8));
    for (int i = 0; i < 8; i++) begin
      rd(2'd2, v); chk("R11 word", v, fdata(16'h40 + 16'(i)));
    end
    wr(2'd1, 32'd0);
    hold = 1;
    wr(2'd1, (32'd5 << 8) | 32'd1);
    rd(2'd1, v); chk("R3 busy before abort", {31'd0, v[1]}, 32'd1);
    wr(2'd1, 32'd0);
    rd(2'd1, v); chk("R7 abort ctrl", v, ctrl_exp(0, 0, 0, 0, 0, DEPTH));
    chk("R7 no request after abort", {31'd0, fl_rd_valid}, 32'd0);
    hold = 0;

    // R5 host push, local drain
    for (int i = 0; i < 10; i++) begin
      pushed[i] = $urandom;
      wr(2'd2, pushed[i]);
    end
    rd(2'd1, v); chk("R5 free after pushes", v >> 16, 32'(DEPTH - 10));
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      loc_pop = 1'b1;
      #1 chk("R5 local word", loc_data, pushed[i]);
      @(posedge clk); #1 loc_pop = 1'b0;
    end
    @(negedge clk);
    chk("R5 local empty", {31'd0, loc_avail}, 32'd0);

    // R6 overflow
    for (int i = 0; i < DEPTH + 1; i++) wr(2'd2, 32'(i + 1));
    rd(2'd1, v); chk("R6 overflow full", v, ctrl_exp(0, 0, 0, 1, 0, 0));
    rd(2'd2, v); chk("R6 head kept", v, 32'd1);
    rd(2'd1, v); chk("R6 sticky", {31'd0, v[3]}, 32'd1);
    wr(2'd1, 32'd0);
    rd(2'd1, v); chk("R7 flush clears", v, ctrl_exp(0, 0, 0, 0, 0, DEPTH));

    // R10 release, then R8 again
    wr(2'd3, 32'd0);
    wait_own(0);
    wr(2'd1, (32'd2 << 8) | 32'd1);
    rd(2'd1, v); chk("R8 refused after release", v[2:0], 32'b101);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule